// File: doc/BRIEF.md
# Byte-Wide Flash Strobe Sequencer

This block turns single-beat requests from inside the chip into read and write cycles on a byte-wide NAND-style flash data bus. Each accepted request produces one strobe cycle. The read or write enable goes low, then returns high. Both phases last one clock plus a programmable number of wait states, so a transfer takes 2(1+n) clocks. Chip enable, the output-enable of the data bus and the write data are driven for the whole cycle. Read data is captured from the bus at the end of the low phase.

A control word sets the wait-state count, the interrupt enable and the chip-enable mode. In pulse mode chip enable follows each cycle. In hold mode it stays asserted across consecutive cycles until the host releases it. Writing the control word with its reset bit set aborts any cycle in progress and returns the block to idle. That bit is not stored. A one-cycle done pulse marks each completed transfer. If interrupts are enabled, completion also sets a sticky interrupt.

Top module: `flash_strobe_seq`

## Requirements
- R1: After rst_n is released, fl_re_n, fl_we_n and fl_ce_n are 1; busy, done, irq and fl_dq_oe are 0; rd_data is 0.
- R2: Control word layout: bit 0 selects hold mode, bit 1 enables interrupts, bit 2 requests soft reset, and bits 8:3 hold the wait count n (0 to 63). An accepted read drives fl_re_n low for exactly n+1 cycles, starting the cycle after acceptance. An accepted write does the same on fl_we_n. The two strobes are never low together.
- R3: After the low phase, the strobe stays high for n+1 more cycles with busy still 1. busy is 1 from the cycle after acceptance through the last high-phase cycle. In the following cycle done is 1 for exactly one cycle.
- R4: The wait count is latched when a request is accepted. A control write during a transfer does not change the length of that transfer.
- R5: For a read, rd_data takes the value on fl_dq_in at the clock edge that ends the last low-phase cycle. It holds that value until the next read completes.
- R6: During a write, fl_dq_oe is 1 and fl_dq_out equals the request data for every busy cycle. fl_dq_oe is 0 whenever the block is not writing.
- R7: In pulse mode (bit 0 clear), fl_ce_n is 0 exactly in the cycles where busy is 1.
- R8: In hold mode (bit 0 set), fl_ce_n goes low with the accepted cycle and stays low after completion. It returns high in the cycle after cs_release is sampled while idle with no request.
- R9: If bit 1 is set when a transfer completes, irq becomes 1 together with done. irq stays 1 until irq_clr is sampled. With bit 1 clear, completion leaves irq unchanged.
- R10: A control write with bit 2 set makes busy 0, both strobes 1, fl_ce_n 1 and irq 0 in the next cycle. The other fields of that word are stored.
- R11: A request presented while busy is ignored. It neither extends nor restarts the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_word | input | 9 | Control word (layout in R2) |
| req_valid | input | 1 | Transfer request, taken when idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write data |
| cs_release | input | 1 | Releases a held chip enable while idle |
| irq_clr | input | 1 | Clears the pending interrupt |
| fl_dq_in | input | 8 | Data bus input from the flash |
| fl_dq_out | output | 8 | Data bus output value |
| fl_dq_oe | output | 1 | Data bus output enable |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_re_n | output | 1 | Read enable strobe, active low |
| fl_we_n | output | 1 | Write enable strobe, active low |
| rd_data | output | 8 | Last captured read byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The hardest situations to reach are a soft reset that lands in the middle of a stretched low phase, and a control rewrite that arrives while a transfer is already running. Both need a request to be accepted first and the disturbing write to be timed several cycles later. The stimulus sets a long wait count, waits a fixed number of cycles after acceptance and then writes the control word. In one run the write also sets hold mode with an interrupt already pending, so a single reset must clear the strobe, chip enable and interrupt together. The bench drives a changing byte onto the input bus every cycle, so a capture one edge early or late gives a different rd_data.

// File: rtl/fss_pkg.sv
package fss_pkg;
    localparam int CW_HOLD     = 0;
    localparam int CW_IRQ_EN   = 1;
    localparam int CW_SRESET   = 2;
    localparam int CW_WAIT_LSB = 3;

    typedef enum logic [1:0] {
        FSS_IDLE = 2'd0,
        FSS_LOW  = 2'd1,
        FSS_HIGH = 2'd2
    } fss_state_e;
endpackage

// File: rtl/fss_cfg_reg.sv
module fss_cfg_reg
    import fss_pkg::*;
#(
    parameter int WAIT_W = 6,
    localparam int CW_W = WAIT_W + CW_WAIT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CW_W-1:0]   word,
    output logic [WAIT_W-1:0] wait_q,
    output logic              irq_en_q,
    output logic              hold_q,
    output logic              sreset
);
    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              irq_en;
        logic              hold;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.waits  = word[CW_WAIT_LSB +: WAIT_W];
            cfg_d.irq_en = word[CW_IRQ_EN];
            cfg_d.hold   = word[CW_HOLD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign wait_q   = cfg_q.waits;
    assign irq_en_q = cfg_q.irq_en;
    assign hold_q   = cfg_q.hold;
    assign sreset   = we & word[CW_SRESET];
endmodule

// File: rtl/fss_phase_timer.sv
module fss_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)              cnt_d = '0;
        else if (load)        cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_strobe_seq.sv
module flash_strobe_seq
    import fss_pkg::*;
#(
    parameter int WAIT_W = 6,
    parameter int DATA_W = 8,
    localparam int CW_W = WAIT_W + CW_WAIT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cs_release,
    input  logic              irq_clr,
    input  logic [DATA_W-1:0] fl_dq_in,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    output logic              fl_ce_n,
    output logic              fl_re_n,
    output logic              fl_we_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    typedef struct packed {
        fss_state_e        state;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [WAIT_W-1:0] waits;
        logic [DATA_W-1:0] rd;
        logic              cs_held;
        logic              done;
        logic              irq;
    } seq_t;

    seq_t s_d, s_q;

    logic [WAIT_W-1:0] cfg_wait;
    logic              cfg_irq_en, cfg_hold, sres;
    logic              t_load, t_expired;
    logic [WAIT_W-1:0] t_val;

    fss_cfg_reg #(.WAIT_W(WAIT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .word(ctrl_word),
        .wait_q(cfg_wait), .irq_en_q(cfg_irq_en), .hold_q(cfg_hold),
        .sreset(sres)
    );

    fss_phase_timer #(.W(WAIT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(sres), .load(t_load),
        .load_val(t_val), .expired(t_expired)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        t_load   = 1'b0;
        t_val    = s_q.waits;
        if (sres) begin
            s_d.state   = FSS_IDLE;
            s_d.cs_held = 1'b0;
            s_d.irq     = 1'b0;
        end else begin
            if (irq_clr) s_d.irq = 1'b0;
            unique case (s_q.state)
                FSS_IDLE: begin
                    if (req_valid) begin
                        s_d.state = FSS_LOW;
                        s_d.wr    = req_write;
                        s_d.wdata = req_wdata;
                        s_d.waits = cfg_wait;
                        t_load    = 1'b1;
                        t_val     = cfg_wait;
                        if (cfg_hold) s_d.cs_held = 1'b1;
                    end else if (cs_release) begin
                        s_d.cs_held = 1'b0;
                    end
                end
                FSS_LOW: begin
                    if (t_expired) begin
                        s_d.state = FSS_HIGH;
                        t_load    = 1'b1;
                        if (!s_q.wr) s_d.rd = fl_dq_in;
                    end
                end
                FSS_HIGH: begin
                    if (t_expired) begin
                        s_d.state = FSS_IDLE;
                        s_d.done  = 1'b1;
                        if (cfg_irq_en) s_d.irq = 1'b1;
                    end
                end
                default: s_d.state = FSS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= FSS_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.state != FSS_IDLE);
    assign fl_re_n   = !((s_q.state == FSS_LOW) && !s_q.wr);
    assign fl_we_n   = !((s_q.state == FSS_LOW) && s_q.wr);
    assign fl_ce_n   = !(busy || s_q.cs_held);
    assign fl_dq_oe  = busy && s_q.wr;
    assign fl_dq_out = s_q.wdata;
    assign rd_data   = s_q.rd;
    assign done      = s_q.done;
    assign irq       = s_q.irq;
endmodule

// File: rtl/fss_checker.sv
module fss_checker
    import fss_pkg::*;
#(
    parameter int WAIT_W = 6,
    localparam int CW_W = WAIT_W + CW_WAIT_LSB,
    localparam int LOW_MAX = (1 << WAIT_W)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_we,
    input logic [CW_W-1:0] ctrl_word,
    input logic            fl_re_n,
    input logic            fl_we_n,
    input logic            fl_ce_n,
    input logic            fl_dq_oe,
    input logic            busy,
    input logic            done,
    input logic            irq
);
    int unsigned low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   low_run <= 0;
        else if (!fl_re_n || !fl_we_n) low_run <= low_run + 1;
        else                          low_run <= 0;
    end

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_re_n && !fl_we_n));

    p_low_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LOW_MAX);

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_ce_covers_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_re_n || !fl_we_n) |-> !fl_ce_n);

    p_oe_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_dq_oe |-> (busy && fl_re_n));

    p_sreset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_word[CW_SRESET]) |=>
            (!busy && fl_re_n && fl_we_n && fl_ce_n && !irq));
endmodule

bind flash_strobe_seq fss_checker #(.WAIT_W(WAIT_W)) u_fss_checker (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_word(ctrl_word),
    .fl_re_n(fl_re_n), .fl_we_n(fl_we_n), .fl_ce_n(fl_ce_n),
    .fl_dq_oe(fl_dq_oe), .busy(busy), .done(done), .irq(irq)
);

// File: tb/flash_strobe_seq_bench.sv
module flash_strobe_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [8:0] ctrl_word = '0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       cs_release = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] fl_dq_in = '0;
    logic [7:0] fl_dq_out, rd_data;
    logic       fl_dq_oe, fl_ce_n, fl_re_n, fl_we_n, busy, done, irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_strobe_seq u_flash_strobe_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_word(ctrl_word),
        .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
        .cs_release(cs_release), .irq_clr(irq_clr), .fl_dq_in(fl_dq_in),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
        .fl_re_n(fl_re_n), .fl_we_n(fl_we_n), .rd_data(rd_data),
        .busy(busy), .done(done), .irq(irq)
    );

    // behavioural reference: remaining-cycle countdown
    int        m_rem = 0, m_n = 0;
    bit        m_wr = 0, m_hold_cs = 0, m_irq = 0, m_done = 0;
    bit [7:0]  m_wdata = 0, m_rd = 0;
    int        c_wait = 0;
    bit        c_irq_en = 0, c_hold = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_rem = 0; m_hold_cs = 0; m_irq = 0; m_done = 0; m_rd = 0;
            m_wdata = 0; m_wr = 0; c_wait = 0; c_irq_en = 0; c_hold = 0;
        end else begin
            m_done = 0;
            if (ctrl_we && ctrl_word[2]) begin
                m_rem = 0; m_hold_cs = 0; m_irq = 0;
            end else begin
                if (irq_clr) m_irq = 0;
                if (m_rem > 0) begin
                    if (m_rem == m_n + 2 && !m_wr) m_rd = fl_dq_in;
                    m_rem--;
                    if (m_rem == 0) begin
                        m_done = 1;
                        if (c_irq_en) m_irq = 1;
                    end
                end else if (req_valid) begin
                    m_n = c_wait; m_rem = 2 * (c_wait + 1);
                    m_wr = req_write; m_wdata = req_wdata;
                    if (c_hold) m_hold_cs = 1;
                end else if (cs_release) begin
                    m_hold_cs = 0;
                end
            end
            if (ctrl_we) begin
                c_wait = int'(ctrl_word[8:3]);
                c_irq_en = ctrl_word[1];
                c_hold = ctrl_word[0];
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit low;
            low = (m_rem > m_n + 1);
            chk("R2 re_n", fl_re_n, !(low && !m_wr));
            chk("R2 we_n", fl_we_n, !(low && m_wr));
            chk("R3 busy", busy, m_rem > 0);
            chk("R3 done", done, m_done);
            chk("R5 rd_data", rd_data, m_rd);
            chk("R6 dq_oe", fl_dq_oe, (m_rem > 0) && m_wr);
            if (m_rem > 0 && m_wr) chk("R6 dq_out", fl_dq_out, m_wdata);
            chk("R7 R8 ce_n", fl_ce_n, !((m_rem > 0) || m_hold_cs));
            chk("R9 irq", irq, m_irq);
        end
        fl_dq_in <= 8'(cyc * 37 + 11);
    end

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic write_ctrl(input int waits, input bit ien, input bit hold, input bit sr);
        ctrl_word = {6'(waits), sr, ien, hold};
        ctrl_we = 1'b1;
        tick(1);
        ctrl_we = 1'b0;
    endtask

    task automatic request(input bit wr, input bit [7:0] d);
        req_valid = 1'b1; req_write = wr; req_wdata = d;
        tick(1);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        tick(1);
        while (busy) tick(1);
        tick(1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 re_n", fl_re_n, 1); chk("R1 we_n", fl_we_n, 1);
        chk("R1 ce_n", fl_ce_n, 1); chk("R1 busy", busy, 0);
        chk("R1 irq", irq, 0);      chk("R1 oe", fl_dq_oe, 0);

        // zero wait states, pulse mode
        request(0, 8'h00); wait_idle();
        request(1, 8'hA5); wait_idle();

        // three wait states with interrupt
        write_ctrl(3, 1, 0, 0);
        request(0, 8'h00); wait_idle();
        chk("R9 irq set", irq, 1);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
        chk("R9 irq cleared", irq, 0);
        write_ctrl(3, 0, 0, 0);
        request(1, 8'h3C); wait_idle();
        chk("R9 irq stays clear", irq, 0);

        // R4 and R11: rewrite control and re-request during a transfer
        write_ctrl(5, 0, 0, 0);
        request(0, 8'h00);
        tick(2);
        write_ctrl(1, 0, 0, 0);
        request(1, 8'hFF);
        tick(1);
        chk("R4 still busy", busy, 1);
        tick(4);
        chk("R4 high phase", busy, 1);
        wait_idle();
        chk("R11 no restart", busy, 0);

        // hold mode, back to back writes
        write_ctrl(2, 0, 1, 0);
        request(1, 8'h11); wait_idle();
        chk("R8 ce held", fl_ce_n, 0);
        request(1, 8'h22); wait_idle();
        chk("R8 ce still held", fl_ce_n, 0);
        cs_release = 1'b1; tick(1); cs_release = 1'b0;
        chk("R8 ce released", fl_ce_n, 1);

        // maximum wait count
        write_ctrl(63, 1, 0, 0);
        request(0, 8'h00); wait_idle();
        chk("R9 irq after long read", irq, 1);

        // soft reset mid low phase, hold mode, irq pending
        write_ctrl(20, 1, 1, 0);
        request(0, 8'h00);
        tick(7);
        write_ctrl(4, 0, 0, 1);
        chk("R10 busy", busy, 0);
        chk("R10 ce_n", fl_ce_n, 1);
        chk("R10 irq", irq, 0);
        chk("R10 re_n", fl_re_n, 1);
        request(0, 8'h00);
        tick(1);
        chk("R10 fields stored", busy, 1);
        wait_idle();
        chk("R10 irq disabled", irq, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule